// File: doc/BRIEF.md
# Eight-bit Timer/Event Counter with Overflow Flag

This block holds one 8-bit count register that can run in one of two ways. As a timer it advances once every 32 machine-cycle strobes, using an internal prescaler. As an event counter it advances on each synchronised high-to-low transition of an external input. A stop command halts either mode. Software can load the register from an 8-bit data input at any time, and the value is always visible on the count output.

When the register rolls over from its maximum value to zero, a sticky overflow flag is set. A test strobe clears the flag, in the same way as a conditional branch that reads and consumes it. A separate interrupt enable decides whether a rollover also raises a pending interrupt request. The request stays up until it is acknowledged or the interrupt is disabled. Arbitration and vectoring of the request belong to the surrounding core.

The run mode is held in a three-state machine: `MODE_IDLE`, `MODE_TIMER` and `MODE_COUNTER`. The transitions are:
- start-timer moves from any state to `MODE_TIMER`, and a start-timer that arrives while already in `MODE_TIMER` is a self-loop that restarts the prescaler;
- start-counter moves from any state to `MODE_COUNTER`;
- stop moves from any state to `MODE_IDLE`.

Top module: `tcnt_unit`

## Requirements
- R1: After reset, count_o is 0x00, flag_o is 0 and irq_o is 0; the block is idle and the interrupt is disabled.
- R2: A load_i pulse places load_data_i on count_o at the next clock edge.
- R3: In timer mode, count_o advances by one on every 32nd mcyc_i strobe. Starting the timer, including while it is already running, clears the prescaler, so that 32 further strobes are needed before the next step.
- R4: In counter mode, count_o advances by one for each high-to-low transition of ext_cnt_i, after a two-stage synchroniser. Rising transitions have no effect.
- R5: stop_i halts both modes. Once stopped, neither mcyc_i strobes nor ext_cnt_i transitions change count_o.
- R6: After reset and before any start, count_o does not respond to mcyc_i strobes or to ext_cnt_i transitions.
- R7: A step from 0xFF to 0x00 sets flag_o. A load never sets the flag.
- R8: A flag_test_i pulse clears flag_o at the next edge. If a rollover occurs in the same cycle as the test, flag_o stays set.
- R9: A rollover raises irq_o only while the interrupt is enabled (irq_en_i sets the enable, irq_dis_i clears it). With the interrupt disabled, a rollover sets flag_o but leaves irq_o low.
- R10: irq_o is cleared by irq_ack_i or by irq_dis_i. irq_dis_i takes priority over irq_en_i arriving in the same cycle.
- R11: Priority among commands: stop_i overrides a start in the same cycle, start-timer overrides start-counter, and load_i overrides an increment in the same cycle.
- R12: Loading the register while it runs does not change the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_tmr_i | input | 1 | Start in timer mode (one-cycle pulse) |
| start_cnt_i | input | 1 | Start in event-counter mode (one-cycle pulse) |
| stop_i | input | 1 | Halt both modes |
| load_i | input | 1 | Load the count register |
| load_data_i | input | 8 | Value to load |
| mcyc_i | input | 1 | Machine-cycle strobe |
| ext_cnt_i | input | 1 | External event input (asynchronous) |
| irq_en_i | input | 1 | Enable the overflow interrupt |
| irq_dis_i | input | 1 | Disable the interrupt and drop any pending request |
| irq_ack_i | input | 1 | Acknowledge the pending request |
| flag_test_i | input | 1 | Test strobe that consumes the overflow flag |
| count_o | output | 8 | Current count |
| flag_o | output | 1 | Overflow flag |
| irq_o | output | 1 | Pending interrupt request |

## Verification
The event-counter path is tried with a table of starting values and edge counts. The table separates plain counting, counting that stops exactly at 0xFF, a single rollover, a rollover from 0xFF itself, counting well past a wrap, and a zero-edge entry that must leave both the count and the flag untouched. Because every edge is a rise followed by a fall, a design that also counted rising edges would give double the expected values.

Timer runs use 31 strobes against 32 to expose any off-by-one in the prescaler, and a restart in the middle of a period to show that the prescaler is cleared. Commands that arrive in the same cycle are used to separate the priority orders. They are stop with start, the two starts together, load with the increment strobe, and a flag test with a rollover.

// File: rtl/tcnt_pkg.sv
package tcnt_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE    = 2'd0,
        MODE_TIMER   = 2'd1,
        MODE_COUNTER = 2'd2
    } tc_mode_e;

endpackage

// File: rtl/tcnt_edge_sync.sv
// Synchronises an asynchronous input and flags its high-to-low transitions.
module tcnt_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic fall_o
);

    logic [STAGES:0] chain_q;

    assign chain_q[0] = async_i;

    generate
        for (genvar g = 1; g <= STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= 1'b0;
                else        chain_q[g] <= chain_q[g-1];
            end
        end
    endgenerate

    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES];
    end

    assign fall_o = prev_q & ~chain_q[STAGES];

endmodule

// File: rtl/tcnt_prescaler.sv
// Divides the machine-cycle strobe by DIV while running.
module tcnt_prescaler #(
    parameter int DIV = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic run_i,
    input  logic strobe_i,
    output logic tick_o
);

    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] presc_q;
    logic          at_last;

    assign at_last = (presc_q == LAST);
    assign tick_o  = run_i & strobe_i & at_last & ~clr_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc_q <= '0;
        end else if (clr_i) begin
            presc_q <= '0;
        end else if (run_i && strobe_i) begin
            presc_q <= at_last ? '0 : presc_q + 1'b1;
        end
    end

endmodule

// File: rtl/tcnt_ctrl.sv
// Run-mode state machine.
module tcnt_ctrl
    import tcnt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_tmr_i,
    input  logic start_cnt_i,
    input  logic stop_i,
    output logic tmr_run_o,
    output logic cnt_run_o,
    output logic presc_clr_o
);

    tc_mode_e mode_q, mode_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_IDLE;
        else        mode_q <= mode_d;
    end

    // Next state: stop > start timer > start counter
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_IDLE: begin
                if (stop_i)           mode_d = MODE_IDLE;
                else if (start_tmr_i) mode_d = MODE_TIMER;
                else if (start_cnt_i) mode_d = MODE_COUNTER;
            end
            MODE_TIMER: begin
                if (stop_i)           mode_d = MODE_IDLE;
                else if (start_tmr_i) mode_d = MODE_TIMER;
                else if (start_cnt_i) mode_d = MODE_COUNTER;
            end
            MODE_COUNTER: begin
                if (stop_i)           mode_d = MODE_IDLE;
                else if (start_tmr_i) mode_d = MODE_TIMER;
                else if (start_cnt_i) mode_d = MODE_COUNTER;
            end
            default: mode_d = MODE_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        tmr_run_o   = (mode_q == MODE_TIMER);
        cnt_run_o   = (mode_q == MODE_COUNTER);
        presc_clr_o = start_tmr_i & ~stop_i;
    end

endmodule

// File: rtl/tcnt_flags.sv
// Overflow flag, interrupt enable and pending request.
module tcnt_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic ovf_i,
    input  logic test_i,
    input  logic en_i,
    input  logic dis_i,
    input  logic ack_i,
    output logic flag_o,
    output logic irq_o
);

    logic flag_q, en_q, pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            en_q   <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            // flag: a rollover beats a test in the same cycle
            if (ovf_i)       flag_q <= 1'b1;
            else if (test_i) flag_q <= 1'b0;

            // enable: disable beats enable
            if (dis_i)     en_q <= 1'b0;
            else if (en_i) en_q <= 1'b1;

            // pending: disable clears; a rollover beats an acknowledge
            if (dis_i)              pend_q <= 1'b0;
            else if (ovf_i && en_q) pend_q <= 1'b1;
            else if (ack_i)         pend_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;
    assign irq_o  = pend_q;

endmodule

// File: rtl/tcnt_unit.sv
module tcnt_unit #(
    parameter int CNT_W       = 8,
    parameter int PRESC_DIV   = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_tmr_i,
    input  logic             start_cnt_i,
    input  logic             stop_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_data_i,
    input  logic             mcyc_i,
    input  logic             ext_cnt_i,
    input  logic             irq_en_i,
    input  logic             irq_dis_i,
    input  logic             irq_ack_i,
    input  logic             flag_test_i,
    output logic [CNT_W-1:0] count_o,
    output logic             flag_o,
    output logic             irq_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic tmr_run, cnt_run, presc_clr;
    logic tmr_tick, ext_fall;
    logic inc, ovf;
    logic [CNT_W-1:0] count_q;

    tcnt_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_tmr_i (start_tmr_i),
        .start_cnt_i (start_cnt_i),
        .stop_i      (stop_i),
        .tmr_run_o   (tmr_run),
        .cnt_run_o   (cnt_run),
        .presc_clr_o (presc_clr)
    );

    tcnt_prescaler #(.DIV(PRESC_DIV)) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (presc_clr),
        .run_i    (tmr_run),
        .strobe_i (mcyc_i),
        .tick_o   (tmr_tick)
    );

    tcnt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ext_cnt_i),
        .fall_o  (ext_fall)
    );

    assign inc = tmr_tick | (cnt_run & ext_fall);
    assign ovf = inc & ~load_i & (count_q == CNT_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      count_q <= '0;
        else if (load_i) count_q <= load_data_i;
        else if (inc)    count_q <= count_q + 1'b1;
    end

    tcnt_flags u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .ovf_i  (ovf),
        .test_i (flag_test_i),
        .en_i   (irq_en_i),
        .dis_i  (irq_dis_i),
        .ack_i  (irq_ack_i),
        .flag_o (flag_o),
        .irq_o  (irq_o)
    );

    assign count_o = count_q;

endmodule

// File: rtl/tcnt_unit_chk.sv
module tcnt_unit_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             stop_i,
    input logic             load_i,
    input logic [CNT_W-1:0] load_data_i,
    input logic             irq_dis_i,
    input logic             irq_ack_i,
    input logic             flag_test_i,
    input logic [CNT_W-1:0] count_o,
    input logic             flag_o,
    input logic             irq_o
);

    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    a_r2_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> count_o == $past(load_data_i));

    a_r5_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(stop_i, 2) && !$past(load_i)) |-> $stable(count_o));

    a_r7_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(count_o) == CMAX && count_o == '0 && !$past(load_i)) |-> flag_o);

    a_r8_test_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flag_test_i) && !($past(count_o) == CMAX && count_o == '0)) |-> !flag_o);

    a_r9_irq_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> flag_o);

    a_r10_dis_drops: assert property (@(posedge clk) disable iff (!rst_n)
        irq_dis_i |=> !irq_o);

    a_r10_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack_i |=> (!irq_o || ($past(count_o) == CMAX && count_o == '0)));

endmodule

bind tcnt_unit tcnt_unit_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .stop_i      (stop_i),
    .load_i      (load_i),
    .load_data_i (load_data_i),
    .irq_dis_i   (irq_dis_i),
    .irq_ack_i   (irq_ack_i),
    .flag_test_i (flag_test_i),
    .count_o     (count_o),
    .flag_o      (flag_o),
    .irq_o       (irq_o)
);

// File: tb/tcnt_unit_tb.sv
`timescale 1ns/1ps
module tcnt_unit_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_tmr_i = 0, start_cnt_i = 0, stop_i = 0, load_i = 0;
    logic [7:0] load_data_i = 8'h00;
    logic       mcyc_i = 0, ext_cnt_i = 0;
    logic       irq_en_i = 0, irq_dis_i = 0, irq_ack_i = 0, flag_test_i = 0;
    logic [7:0] count_o;
    logic       flag_o, irq_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    tcnt_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .start_tmr_i(start_tmr_i), .start_cnt_i(start_cnt_i), .stop_i(stop_i),
        .load_i(load_i), .load_data_i(load_data_i), .mcyc_i(mcyc_i),
        .ext_cnt_i(ext_cnt_i), .irq_en_i(irq_en_i), .irq_dis_i(irq_dis_i),
        .irq_ack_i(irq_ack_i), .flag_test_i(flag_test_i),
        .count_o(count_o), .flag_o(flag_o), .irq_o(irq_o)
    );

    // {load value, falling edges, expected count, expected flag}
    localparam logic [24:0] VEC [7] = '{
        {8'h00, 8'd3,  8'h03, 1'b0},
        {8'hFE, 8'd1,  8'hFF, 1'b0},
        {8'hFE, 8'd2,  8'h00, 1'b1},
        {8'hFF, 8'd1,  8'h00, 1'b1},
        {8'hF0, 8'd20, 8'h04, 1'b1},
        {8'h7F, 8'd5,  8'h84, 1'b0},
        {8'h55, 8'd0,  8'h55, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_load(input logic [7:0] v);
        load_i = 1; load_data_i = v; step(); load_i = 0;
    endtask

    task automatic strobes(input int n);
        for (int i = 0; i < n; i++) begin
            mcyc_i = 1; step(); mcyc_i = 0; step();
        end
    endtask

    task automatic ext_edges(input int n);
        for (int i = 0; i < n; i++) begin
            ext_cnt_i = 1; repeat (4) step();
            ext_cnt_i = 0; repeat (4) step();
        end
    endtask

    task automatic pulse_test();  flag_test_i = 1; step(); flag_test_i = 0; endtask
    task automatic pulse_tmr();   start_tmr_i = 1; step(); start_tmr_i = 0; endtask
    task automatic pulse_cnt();   start_cnt_i = 1; step(); start_cnt_i = 0; endtask
    task automatic pulse_stop();  stop_i = 1; step(); stop_i = 0; endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1; step();
        // R1 reset state
        check("R1 count", count_o, 8'h00);
        check("R1 flag", flag_o, 0);
        check("R1 irq", irq_o, 0);

        // R6 idle ignores strobes and edges
        strobes(40); ext_edges(2);
        check("R6 idle hold", count_o, 8'h00);

        // R4 / R7 table-driven counter runs (interrupt disabled)
        pulse_cnt();
        for (int k = 0; k < 7; k++) begin
            pulse_test();
            do_load(VEC[k][24:17]);
            check("R2 load", count_o, VEC[k][24:17]);
            ext_edges(int'(VEC[k][16:9]));
            check("R4 count", count_o, VEC[k][8:1]);
            check("R7 flag", flag_o, VEC[k][0]);
        end
        check("R9 no irq while disabled", irq_o, 0);

        // R8 test clears flag
        do_load(8'hFF); ext_edges(1);
        pulse_test();
        check("R8 cleared", flag_o, 0);

        // R5 stop halts counter
        pulse_stop();
        do_load(8'h20);
        ext_edges(3); strobes(40);
        check("R5 stopped", count_o, 8'h20);

        // R3 timer: 31 strobes no step, 32nd steps
        pulse_tmr();
        strobes(31);
        check("R3 31 strobes", count_o, 8'h20);
        strobes(1);
        check("R3 32 strobes", count_o, 8'h21);
        ext_edges(2);
        check("R3 timer ignores ext", count_o, 8'h21);
        // R3 restart clears prescaler
        strobes(20); pulse_tmr(); strobes(31);
        check("R3 restart clear", count_o, 8'h21);
        strobes(1);
        check("R3 restart step", count_o, 8'h22);
        // R12 load in timer keeps mode
        do_load(8'h10); strobes(32);
        check("R12 mode kept", count_o, 8'h11);

        // R11 load beats increment (32nd strobe with load)
        strobes(31);
        mcyc_i = 1; load_i = 1; load_data_i = 8'h40; step();
        mcyc_i = 0; load_i = 0; step();
        check("R11 load over inc", count_o, 8'h40);

        // R8 rollover in same cycle as test keeps flag set
        pulse_test();
        do_load(8'hFF); strobes(31);
        mcyc_i = 1; flag_test_i = 1; step();
        mcyc_i = 0; flag_test_i = 0; step();
        check("R8 ovf beats test", flag_o, 1);
        check("R7 timer wrap", count_o, 8'h00);

        // R9 interrupt enabled
        pulse_test();
        irq_en_i = 1; step(); irq_en_i = 0;
        do_load(8'hFF); strobes(32);
        check("R9 irq raised", irq_o, 1);
        irq_ack_i = 1; step(); irq_ack_i = 0; step();
        check("R10 ack clears", irq_o, 0);
        do_load(8'hFF); strobes(32);
        check("R9 irq again", irq_o, 1);
        irq_dis_i = 1; irq_en_i = 1; step(); irq_dis_i = 0; irq_en_i = 0; step();
        check("R10 dis clears", irq_o, 0);
        do_load(8'hFF); strobes(32);
        check("R10 dis beats en", irq_o, 0);

        // R11 stop beats start
        pulse_stop();
        stop_i = 1; start_tmr_i = 1; step(); stop_i = 0; start_tmr_i = 0;
        do_load(8'h05); strobes(32);
        check("R11 stop over start", count_o, 8'h05);
        // R11 start timer beats start counter
        start_tmr_i = 1; start_cnt_i = 1; step(); start_tmr_i = 0; start_cnt_i = 0;
        ext_edges(2);
        check("R11 not counter", count_o, 8'h05);
        strobes(32);
        check("R11 timer chosen", count_o, 8'h06);

        // R1 reset clears flag and request
        do_load(8'hFF); irq_en_i = 1; step(); irq_en_i = 0; strobes(32);
        rst_n = 0; step(); rst_n = 1; step();
        check("R1 reset count", count_o, 8'h00);
        check("R1 reset flag", flag_o, 0);
        check("R1 reset irq", irq_o, 0);
        strobes(40);
        check("R1 reset stopped", count_o, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule